// File: doc/BRIEF.md
# Double-Edge Pulse Width Capture Channel

This channel measures how long an input pulse lasts, using a shared 16-bit time base that it does not own. The input pin goes through a two-flop synchronizer. A change in the synchronized level counts as a leading or trailing edge, depending on a polarity bit. On the leading edge the current counter-bus value goes into a hidden staging register. On the trailing edge the bus value goes into the trailing register, and the staged value moves into the software-visible leading register in the same cycle. Software therefore always reads a matched pair. That pair stays valid while the next pulse begins, and the width is trailing minus leading, modulo 2^16.

A small state machine runs the channel. It has three states:
- **OFF**: the channel is disabled.
- **WAIT_LEAD**: the channel is armed and waiting for the first edge.
- **WAIT_TRAIL**: the leading edge has been captured and the channel waits for the second edge.

The transitions are:
- **enable** takes OFF to WAIT_LEAD.
- **lead_seen** takes WAIT_LEAD to WAIT_TRAIL.
- **trail_seen** takes WAIT_TRAIL to WAIT_LEAD.
- **disable** takes any state to OFF.

When a pair completes, the channel sets a pending flag, which drives the interrupt request. An optional control bit also sets the flag on the leading edge. A sticky overrun flag records that a pair completed before software had cleared the previous request.

A simple register port gives access to everything. Reads are combinational and writes take effect at the next clock edge. The register map is:

| Address | Register | Access | Fields |
|---|---|---|---|
| 0 | CTRL | read/write | bit0 enable, bit1 polarity (0: rising is leading, 1: falling is leading), bit2 first-edge request enable |
| 1 | STATUS | read, with write-1-to-clear on bits 0 and 1 | bit0 pending, bit1 overrun, bit2 armed (state WAIT_TRAIL, read-only) |
| 2 | LEAD | read-only | leading-edge sample |
| 3 | TRAIL | read-only | trailing-edge sample |

Top module: `pwcap_top`

## Requirements
- R1: After reset, CTRL, STATUS, LEAD and TRAIL read 0 and irq is 0.
- R2: If the input pin changes level and the change is first sampled at clock edge k, any capture it causes takes the cnt_bus value present at clock edge k+2.
- R3: When first-edge requests are disabled (CTRL bit2 = 0), irq stays 0 after a leading edge and becomes 1 after the trailing edge of the same pulse; irq always equals STATUS bit0.
- R4: A leading-edge capture alone leaves the readable LEAD unchanged. On the trailing capture, LEAD takes the staged leading sample in the same cycle that TRAIL is written.
- R5: A trailing edge in state WAIT_TRAIL writes the bus value into TRAIL (address 3) and returns the channel to WAIT_LEAD.
- R6: With CTRL bit2 = 1, a leading edge captured in WAIT_LEAD also sets the pending bit.
- R7: With CTRL bit1 = 0 a rising synchronized level is the leading edge; with CTRL bit1 = 1 a falling level is the leading edge and a rising level is the trailing edge.
- R8: Writing 1 to STATUS bit0 clears the pending bit. If a request occurs in the same cycle, the bit stays 1.
- R9: STATUS bit1 (overrun) sets when a trailing capture occurs while the pending bit is already 1, including in the same cycle as a clear write. It stays set until 1 is written to STATUS bit1.
- R10: With CTRL bit0 = 0 the channel is in OFF: edges capture nothing, request nothing and STATUS bit2 reads 0. Writes to addresses 2 and 3 have no effect.
- R11: TRAIL minus LEAD, modulo 2^16, equals the number of bus ticks between the edges, even if the counter wraps once between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_bus | input | 16 | Shared free-running time-base value |
| pin_in | input | 1 | Asynchronous pulse input |
| reg_addr | input | 2 | Register select (0 CTRL, 1 STATUS, 2 LEAD, 3 TRAIL) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| irq | output | 1 | Interrupt request, equal to the pending bit |

## Verification
The assertions assume that cnt_bus changes at most once per system clock. This matches a tick no faster than the clock. The stimulus meets this by moving the bus by at most one count on each falling clock edge.

The assertions also assume the polarity bit is changed only while the channel is disabled. Random stimulus writes CTRL only during disabled windows.

The pin is driven away from the active edge. This makes the two-flop latency deterministic, so the expected capture values depend only on the bus value two edges after each pin change.

// File: rtl/pwcap_pkg.sv
package pwcap_pkg;

    typedef enum logic [1:0] {
        ST_OFF        = 2'd0,
        ST_WAIT_LEAD  = 2'd1,
        ST_WAIT_TRAIL = 2'd2
    } cap_state_e;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd1;
    localparam logic [ADDR_W-1:0] A_LEAD   = 2'd2;
    localparam logic [ADDR_W-1:0] A_TRAIL  = 2'd3;

    localparam int CB_EN    = 0;
    localparam int CB_POL   = 1;
    localparam int CB_FIRST = 2;
    localparam int CTRL_W   = 3;

    localparam int SB_PEND  = 0;
    localparam int SB_OVR   = 1;
    localparam int SB_ARMED = 2;

endpackage

// File: rtl/pwcap_sync_edge.sv
module pwcap_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] shift_q;
    logic              prev_q;
    logic              lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], pin_i};
            prev_q  <= shift_q[STAGES-1];
        end
    end

    assign lvl    = shift_q[STAGES-1];
    assign rise_o = lvl & ~prev_q;
    assign fall_o = ~lvl & prev_q;

endmodule

// File: rtl/pwcap_fsm.sv
module pwcap_fsm
    import pwcap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic pol_i,
    input  logic rise_i,
    input  logic fall_i,
    output logic cap_stage_o,
    output logic cap_pair_o,
    output logic armed_o
);

    cap_state_e state_q, state_d;
    logic       lead_edge, trail_edge;

    assign lead_edge  = pol_i ? fall_i : rise_i;
    assign trail_edge = pol_i ? rise_i : fall_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:        state_d = ST_WAIT_LEAD;
                ST_WAIT_LEAD:  if (lead_edge)  state_d = ST_WAIT_TRAIL;
                ST_WAIT_TRAIL: if (trail_edge) state_d = ST_WAIT_LEAD;
                default:       state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        cap_stage_o = 1'b0;
        cap_pair_o  = 1'b0;
        armed_o     = 1'b0;
        unique case (state_q)
            ST_OFF: ;
            ST_WAIT_LEAD:  cap_stage_o = lead_edge;
            ST_WAIT_TRAIL: begin
                cap_pair_o = trail_edge;
                armed_o    = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pwcap_regs.sv
module pwcap_regs
    import pwcap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              cap_stage_i,
    input  logic              cap_pair_i,
    input  logic              armed_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]  rdata_o,
    output logic              en_o,
    output logic              pol_o,
    output logic              pend_o,
    output logic              ovr_o,
    output logic [CNT_W-1:0]  lead_o,
    output logic [CNT_W-1:0]  trail_o,
    output logic [CNT_W-1:0]  stage_o
);

    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  stage_q, lead_q, trail_q;
    logic              pend_q, ovr_q;
    logic              wr_ctrl, clr_pend, clr_ovr, set_pend;

    assign wr_ctrl  = wr_i && (addr_i == A_CTRL);
    assign clr_pend = wr_i && (addr_i == A_STATUS) && wdata_i[SB_PEND];
    assign clr_ovr  = wr_i && (addr_i == A_STATUS) && wdata_i[SB_OVR];
    assign set_pend = cap_pair_i || (cap_stage_i && ctrl_q[CB_FIRST]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= wdata_i[CTRL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            lead_q  <= '0;
            trail_q <= '0;
        end else begin
            if (cap_stage_i) stage_q <= cnt_i;
            if (cap_pair_i) begin
                lead_q  <= stage_q;
                trail_q <= cnt_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (set_pend)      pend_q <= 1'b1;
            else if (clr_pend) pend_q <= 1'b0;
            if (cap_pair_i && pend_q) ovr_q <= 1'b1;
            else if (clr_ovr)         ovr_q <= 1'b0;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            A_CTRL:   rdata_o[CTRL_W-1:0] = ctrl_q;
            A_STATUS: begin
                rdata_o[SB_PEND]  = pend_q;
                rdata_o[SB_OVR]   = ovr_q;
                rdata_o[SB_ARMED] = armed_i;
            end
            A_LEAD:   rdata_o = lead_q;
            A_TRAIL:  rdata_o = trail_q;
            default:  rdata_o = '0;
        endcase
    end

    assign en_o    = ctrl_q[CB_EN];
    assign pol_o   = ctrl_q[CB_POL];
    assign pend_o  = pend_q;
    assign ovr_o   = ovr_q;
    assign lead_o  = lead_q;
    assign trail_o = trail_q;
    assign stage_o = stage_q;

endmodule

// File: rtl/pwcap_top.sv
module pwcap_top
    import pwcap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_bus,
    input  logic              pin_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq
);

    logic             rise, fall;
    logic             cap_stage, cap_pair, armed;
    logic             ctl_en, ctl_pol, pend, ovr;
    logic [CNT_W-1:0] lead_q, trail_q, stage_q;

    pwcap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_in),
        .rise_o (rise),
        .fall_o (fall)
    );

    pwcap_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (ctl_en),
        .pol_i       (ctl_pol),
        .rise_i      (rise),
        .fall_i      (fall),
        .cap_stage_o (cap_stage),
        .cap_pair_o  (cap_pair),
        .armed_o     (armed)
    );

    pwcap_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_i       (cnt_bus),
        .cap_stage_i (cap_stage),
        .cap_pair_i  (cap_pair),
        .armed_i     (armed),
        .addr_i      (reg_addr),
        .wr_i        (reg_wr),
        .wdata_i     (reg_wdata),
        .rdata_o     (reg_rdata),
        .en_o        (ctl_en),
        .pol_o       (ctl_pol),
        .pend_o      (pend),
        .ovr_o       (ovr),
        .lead_o      (lead_q),
        .trail_o     (trail_q),
        .stage_o     (stage_q)
    );

    assign irq = pend;

endmodule

// File: rtl/pwcap_chk.sv
module pwcap_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_bus,
    input logic             cap_stage,
    input logic             cap_pair,
    input logic             ctl_en,
    input logic             pend,
    input logic             ovr,
    input logic             irq,
    input logic [CNT_W-1:0] lead_q,
    input logic [CNT_W-1:0] trail_q,
    input logic [CNT_W-1:0] stage_q
);

    p_pair_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pair |=> lead_q == $past(stage_q));

    p_lead_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_pair |=> $stable(lead_q));

    p_trail_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pair |=> trail_q == $past(cnt_bus));

    p_pair_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pair |=> irq);

    p_overrun_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_pair && pend) |=> ovr);

    p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && !$past(ctl_en)) |-> !cap_stage && !cap_pair);

    p_one_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cap_stage, cap_pair}));

endmodule

bind pwcap_top pwcap_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_bus   (cnt_bus),
    .cap_stage (cap_stage),
    .cap_pair  (cap_pair),
    .ctl_en    (ctl_en),
    .pend      (pend),
    .ovr       (ovr),
    .irq       (irq),
    .lead_q    (lead_q),
    .trail_q   (trail_q),
    .stage_q   (stage_q)
);

// File: tb/test_pwcap_top.sv
`timescale 1ns/100ps
module test_pwcap_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_bus = '0;
    logic        pin_in = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pwcap_top i_pwcap_top (
        .clk(clk), .rst_n(rst_n), .cnt_bus(cnt_bus), .pin_in(pin_in),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // reference model state
    bit        m_en, m_pol, m_first, m_pend, m_ovr;
    int        m_state;              // 0 off, 1 wait lead, 2 wait trail
    logic [15:0] m_stage, m_lead, m_trail;
    int        ev0, ev1, ev2;        // 0 none, 1 rise, 2 fall
    bit        last_pin;
    bit        tick_all = 1;
    int        tick_pct = 100;
    bit        w_pend_req;
    logic [1:0]  w_addr;
    logic [15:0] w_data;

    function automatic logic [15:0] width16(input logic [15:0] a, input logic [15:0] b);
        return b - a;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: drive inputs at falling edge, advance model to next rising edge
    task automatic step(input bit p);
        bit lead_e, trail_e, cap_s, cap_p, set_p, clr_p, clr_o;
        @(negedge clk);
        pin_in    = p;
        reg_wr    = w_pend_req;
        reg_addr  = w_addr;
        reg_wdata = w_data;
        if (tick_all || ($urandom_range(0, 99) < tick_pct)) cnt_bus = cnt_bus + 16'd1;
        ev2 = ev1; ev1 = ev0;
        ev0 = (p == last_pin) ? 0 : (p ? 1 : 2);
        last_pin = p;
        lead_e  = m_pol ? (ev2 == 2) : (ev2 == 1);
        trail_e = m_pol ? (ev2 == 1) : (ev2 == 2);
        cap_s = (m_state == 1) && lead_e;
        cap_p = (m_state == 2) && trail_e;
        set_p = cap_p || (cap_s && m_first);
        clr_p = w_pend_req && w_addr == 2'd1 && w_data[0];
        clr_o = w_pend_req && w_addr == 2'd1 && w_data[1];
        if (cap_p && m_pend) m_ovr = 1; else if (clr_o) m_ovr = 0;
        if (set_p) m_pend = 1; else if (clr_p) m_pend = 0;
        if (cap_s) m_stage = cnt_bus;
        if (cap_p) begin m_lead = m_stage; m_trail = cnt_bus; end
        if (!m_en) m_state = 0;
        else if (m_state == 0) m_state = 1;
        else if (m_state == 1 && lead_e) m_state = 2;
        else if (m_state == 2 && trail_e) m_state = 1;
        if (w_pend_req && w_addr == 2'd0) begin
            m_en = w_data[0]; m_pol = w_data[1]; m_first = w_data[2];
        end
        w_pend_req = 0;
    endtask

    task automatic wr_step(input logic [1:0] a, input logic [15:0] d, input bit p);
        w_pend_req = 1; w_addr = a; w_data = d;
        step(p);
    endtask

    task automatic hold(input int n);
        for (int i = 0; i < n; i++) step(last_pin);
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        reg_wr = 0;
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic check_all(input string req);
        logic [15:0] v;
        rd(2'd0, v); chk({req, " CTRL"}, v, {13'd0, m_first, m_pol, m_en});
        rd(2'd1, v); chk({req, " STATUS"}, v, {13'd0, m_state == 2, m_ovr, m_pend});
        rd(2'd2, v); chk({req, " LEAD"}, v, m_lead);
        rd(2'd3, v); chk({req, " TRAIL"}, v, m_trail);
        chk({req, " irq"}, {15'd0, irq}, {15'd0, m_pend});
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] cnt_at, v, old_lead;
        void'($urandom(32'h1234_5678));
        m_state = 0; m_en = 0; m_pol = 0; m_first = 0; m_pend = 0; m_ovr = 0;
        m_stage = 0; m_lead = 0; m_trail = 0; ev0 = 0; ev1 = 0; ev2 = 0;
        last_pin = 0; w_pend_req = 0; w_addr = 0; w_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #0.5;
        check_all("R1 reset");

        // R2/R5 directed: bus ticks every clock
        wr_step(2'd0, 16'h0001, 0);
        hold(3);
        step(1);
        cnt_at = cnt_bus;
        hold(6);
        step(0);
        hold(4);
        rd(2'd2, v); chk("R2 lead latency", v, cnt_at + 16'd2);
        rd(2'd3, v); chk("R5 trail latency", v, cnt_at + 16'd9);
        check_all("R5 pair");

        // R3: no request after leading edge only
        wr_step(2'd1, 16'h0003, 0);
        hold(2);
        step(1); hold(4);
        chk("R3 no irq after lead", {15'd0, irq}, 16'd0);
        rd(2'd1, v); chk("R10 armed while waiting trail", {15'd0, v[2]}, 16'd1);
        // R4: readable LEAD still holds previous pair
        rd(2'd2, v); chk("R4 lead held", v, m_lead);
        old_lead = v;
        step(0); hold(4);
        chk("R3 irq after trail", {15'd0, irq}, 16'd1);
        rd(2'd2, v);
        total++;
        if (v == old_lead) begin bad++; $display("FAIL R4 lead not updated actual=%h expected!=%h", v, old_lead); end
        check_all("R4 new pair");

        // R9 overrun: pend still set when next pair completes
        step(1); hold(4); step(0); hold(4);
        rd(2'd1, v); chk("R9 overrun", {15'd0, v[1]}, 16'd1);
        wr_step(2'd1, 16'h0002, 0); hold(1);
        rd(2'd1, v); chk("R9 overrun cleared, pend kept", v & 16'h3, 16'h1);
        wr_step(2'd1, 16'h0001, 0); hold(1);
        chk("R8 pend cleared", {15'd0, irq}, 16'd0);

        // R8 same-cycle clear and request: request wins
        step(1); hold(4);
        step(0); step(0);
        wr_step(2'd1, 16'h0001, 0);
        hold(1);
        chk("R8 set wins over clear", {15'd0, irq}, 16'd1);
        check_all("R8 collision");
        wr_step(2'd1, 16'h0003, 0); hold(1);

        // R6 first-edge request
        wr_step(2'd0, 16'h0005, 0); hold(2);
        step(1); hold(3);
        chk("R6 irq on leading edge", {15'd0, irq}, 16'd1);
        step(0); hold(4);
        check_all("R6 pair");
        wr_step(2'd1, 16'h0003, 0); hold(1);

        // R7 falling-edge polarity
        wr_step(2'd0, 16'h0000, 0);
        step(1); hold(4);
        wr_step(2'd0, 16'h0003, 1); hold(3);
        step(0); cnt_at = cnt_bus; hold(5);
        step(1); hold(4);
        rd(2'd2, v); chk("R7 falling is leading", v, cnt_at + 16'd2);
        check_all("R7 pair");
        wr_step(2'd1, 16'h0003, 1);
        wr_step(2'd0, 16'h0000, 1);
        step(0); hold(3);

        // R10 disabled: edges and LEAD/TRAIL writes ignored
        for (int i = 0; i < 3; i++) begin step(1); hold(3); step(0); hold(3); end
        wr_step(2'd2, 16'hBEEF, 0);
        wr_step(2'd3, 16'hCAFE, 0);
        hold(1);
        check_all("R10 disabled");

        // R11 wrap between edges
        cnt_bus = 16'hFFF0;
        wr_step(2'd0, 16'h0001, 0); hold(2);
        step(1); hold(29); step(0); hold(4);
        rd(2'd2, old_lead); rd(2'd3, v);
        chk("R11 wrapped width", width16(old_lead, v), 16'd30);
        check_all("R11 wrap");
        wr_step(2'd1, 16'h0003, 0);

        // random pulses with sparse bus ticks
        tick_all = 0;
        for (int n = 0; n < 300; n++) begin
            tick_pct = $urandom_range(5, 100);
            if ($urandom_range(0, 9) == 0) begin
                wr_step(2'd0, 16'h0000, last_pin);
                hold(3);
                wr_step(2'd0, {13'd0, 3'($urandom_range(0, 7)) | 3'b001}, last_pin);
            end
            step(~last_pin);
            hold($urandom_range(0, 12));
            if ($urandom_range(0, 3) == 0)
                wr_step(2'd1, 16'($urandom_range(0, 3)), last_pin);
            if (n % 10 == 0) begin
                hold(3);
                check_all("R3 R4 R5 R7 R9 random");
            end
        end
        hold(4);
        check_all("R11 random end");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule